// File: doc/BRIEF.md
# Sequential Shift-and-Add Multiplier

This block multiplies two unsigned operands of `WIDTH` bits and returns a product of `2*WIDTH` bits. It takes one add step and one shift step for each multiplier bit. The datapath has five storage elements:

- an operand register for the multiplicand;
- a shift register for the multiplier, whose low end also collects the low half of the product;
- an accumulator that holds the upper half of the partial product and can be loaded in parallel or shifted;
- a carry flip-flop;
- a down-counter for the remaining steps.

A hardwired controller with one flip-flop per state sequences the datapath. It has four named states:

- IDLE: wait for a start request.
- LOAD: clear the accumulator and carry, capture both operands and set the counter to `WIDTH`.
- ADD: add the multiplicand into the accumulator when the current multiplier bit is 1, and decrement the counter.
- SHIFT: shift carry, accumulator and multiplier right by one place.

The controller moves between these states as follows:

- IDLE→IDLE when start is low.
- IDLE→LOAD when start is high.
- LOAD→ADD.
- ADD→SHIFT.
- SHIFT→ADD while the counter is non-zero.
- SHIFT→IDLE once the counter reads zero.

Reset clears every state flip-flop. The all-zero state then enters IDLE on the next edge.

A user raises `start` while `idle` is high and holds the operands for the following cycle. The user then waits for `done`. The result stays on `product` until the next start is accepted.

Top module: `shift_add_mult`

## Requirements
- R1: While `rst_n` is low, `idle`, `done` and `product` are 0. On the first clock edge after reset is released, the block enters IDLE, so `idle` reads 1 after that edge.
- R2: In IDLE, `start` high at a clock edge is accepted and `idle` goes low after that edge. `start` low keeps the block in IDLE.
- R3: Counting the accepting edge as edge 0, `idle` and `done` both go high after edge 2*WIDTH+1. This covers one LOAD cycle and WIDTH ADD/SHIFT pairs.
- R4: When `done` is high, `product` equals the unsigned product of the two operands, zero-extended to 2*WIDTH bits (for example 23 × 19 = 437). This includes the cases 0 × x and all-ones × all-ones.
- R5: The operands are sampled only on edge 1, the edge that follows the accepting edge. Changing `mcand` or `mplier` at any later time during the run does not alter the result.
- R6: `start` is ignored while the block is not in IDLE. Neither the run length nor the result changes.
- R7: `done` stays high and `product` stays unchanged for as long as the block is idle. `done` drops after the edge that accepts the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, accepted only in IDLE |
| mcand | input | WIDTH | Multiplicand |
| mplier | input | WIDTH | Multiplier |
| product | output | 2*WIDTH | Concatenation of accumulator and multiplier register |
| idle | output | 1 | High in IDLE |
| done | output | 1 | High from the end of a run until the next start is accepted |

## Verification
Each fault shows up at the ports in a different way:

- A corrupted state flip-flop moves the cycle in which `idle` returns, or stops it from returning at all. The per-cycle compare catches this at the first sample after the expected edge.
- A wrong step count or a miscounted loop exit shifts the `done` edge by a multiple of two cycles.
- Wrong add or shift logic leaves `idle` timing intact but gives a wrong `product` at the first sample with `done` high.
- A stray datapath update while idle breaks the stable-result rule on the very next cycle.

// File: rtl/mult_pkg.sv
package mult_pkg;

    // One flip-flop per state; the all-zero code is the post-reset state.
    typedef enum logic [3:0] {
        ST_NONE  = 4'b0000,
        ST_IDLE  = 4'b0001,
        ST_LOAD  = 4'b0010,
        ST_ADD   = 4'b0100,
        ST_SHIFT = 4'b1000
    } mult_state_t;

    localparam int unsigned BIT_IDLE  = 0;
    localparam int unsigned BIT_LOAD  = 1;
    localparam int unsigned BIT_ADD   = 2;
    localparam int unsigned BIT_SHIFT = 3;

endpackage

// File: rtl/mult_ctrl.sv
module mult_ctrl
    import mult_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic cnt_zero,
    output logic do_load,
    output logic do_add,
    output logic do_shift,
    output logic idle,
    output logic done
);

    mult_state_t state_q;
    logic [3:0]  nxt;
    logic        s_idle, s_load, s_add, s_shift;

    assign s_idle  = state_q[BIT_IDLE];
    assign s_load  = state_q[BIT_LOAD];
    assign s_add   = state_q[BIT_ADD];
    assign s_shift = state_q[BIT_SHIFT];

    // Explicit one-hot next-state equations; the last IDLE term pulls
    // the all-zero post-reset code into IDLE.
    always_comb begin
        nxt[BIT_IDLE]  = (s_idle & ~start) | (s_shift & cnt_zero)
                       | ~(s_idle | s_load | s_add | s_shift);
        nxt[BIT_LOAD]  = s_idle & start;
        nxt[BIT_ADD]   = s_load | (s_shift & ~cnt_zero);
        nxt[BIT_SHIFT] = s_add;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_NONE;
        end else begin
            state_q <= mult_state_t'(nxt);
        end
    end

    // Decoded datapath controls
    always_comb begin
        do_load  = 1'b0;
        do_add   = 1'b0;
        do_shift = 1'b0;
        idle     = 1'b0;
        unique case (state_q)
            ST_NONE:  ;
            ST_IDLE:  idle     = 1'b1;
            ST_LOAD:  do_load  = 1'b1;
            ST_ADD:   do_add   = 1'b1;
            ST_SHIFT: do_shift = 1'b1;
            default:  ;
        endcase
    end

    // Completion flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else if (s_idle && start) begin
            done <= 1'b0;
        end else if (s_shift && cnt_zero) begin
            done <= 1'b1;
        end
    end

    p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(state_q));
    p_reset_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NONE) |=> (state_q == ST_IDLE));
    p_start_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_idle && start) |=> (state_q == ST_LOAD));
    p_add_then_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
        s_add |=> s_shift);
    p_busy_ignores_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_add || s_shift || s_load) |=> !s_load);

endmodule

// File: rtl/mult_dpath.sv
module mult_dpath #(
    parameter int unsigned WIDTH = 8,
    localparam int unsigned CW   = $clog2(WIDTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               do_load,
    input  logic               do_add,
    input  logic               do_shift,
    input  logic [WIDTH-1:0]   mcand,
    input  logic [WIDTH-1:0]   mplier,
    output logic               cnt_zero,
    output logic [2*WIDTH-1:0] product
);

    localparam logic [CW-1:0] STEPS = CW'(WIDTH);

    logic [WIDTH-1:0] b_q;
    logic [WIDTH-1:0] a_q;
    logic [WIDTH-1:0] q_q;
    logic             c_q;
    logic [CW-1:0]    cnt_q;
    logic [WIDTH:0]   sum;

    assign sum      = {1'b0, a_q} + {1'b0, b_q};
    assign cnt_zero = (cnt_q == '0);
    assign product  = {a_q, q_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q   <= '0;
            a_q   <= '0;
            q_q   <= '0;
            c_q   <= 1'b0;
            cnt_q <= '0;
        end else if (do_load) begin
            b_q   <= mcand;
            q_q   <= mplier;
            a_q   <= '0;
            c_q   <= 1'b0;
            cnt_q <= STEPS;
        end else if (do_add) begin
            if (q_q[0]) begin
                {c_q, a_q} <= sum;
            end
            cnt_q <= cnt_q - 1'b1;
        end else if (do_shift) begin
            c_q <= 1'b0;
            a_q <= {c_q, a_q[WIDTH-1:1]};
            q_q <= {a_q[0], q_q[WIDTH-1:1]};
        end
    end

    p_counter_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        do_load |=> (cnt_q == STEPS));
    p_operand_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (do_add || do_shift) |=> $stable(b_q));
    p_carry_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        do_shift |=> !c_q);
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(do_load || do_add || do_shift) |=> $stable(product));

endmodule

// File: rtl/shift_add_mult.sv
module shift_add_mult #(
    parameter int unsigned WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [WIDTH-1:0]   mcand,
    input  logic [WIDTH-1:0]   mplier,
    output logic [2*WIDTH-1:0] product,
    output logic               idle,
    output logic               done
);

    logic do_load, do_add, do_shift, cnt_zero;

    mult_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cnt_zero (cnt_zero),
        .do_load  (do_load),
        .do_add   (do_add),
        .do_shift (do_shift),
        .idle     (idle),
        .done     (done)
    );

    mult_dpath #(.WIDTH(WIDTH)) u_dpath (
        .clk      (clk),
        .rst_n    (rst_n),
        .do_load  (do_load),
        .do_add   (do_add),
        .do_shift (do_shift),
        .mcand    (mcand),
        .mplier   (mplier),
        .cnt_zero (cnt_zero),
        .product  (product)
    );

    p_done_implies_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> idle);
    p_done_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(cnt_zero));

endmodule

// File: tb/test_shift_add_mult.sv
module test_shift_add_mult;

    localparam int W   = 8;
    localparam int RUN = 2 * W + 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [W-1:0]     mcand = '0;
    logic [W-1:0]     mplier = '0;
    logic [2*W-1:0]   product;
    logic             idle;
    logic             done;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit finished = 1'b0;
    string tag = "R4";

    always #4 clk = ~clk;   // 125 MHz

    shift_add_mult #(.WIDTH(W)) i_shift_add_mult (
        .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand),
        .mplier(mplier), .product(product), .idle(idle), .done(done)
    );

    // Behavioural reference: remaining edges until idle, result value.
    int           m_busy;
    bit           m_run;
    bit           m_done;
    logic [2*W-1:0] m_exp;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_busy = 1;
            m_run  = 1'b0;
            m_done = 1'b0;
            m_exp  = '0;
        end else if (m_busy == 0) begin
            if (start) begin
                m_busy = RUN;
                m_run  = 1'b1;
                m_done = 1'b0;
            end
        end else begin
            if (m_run && m_busy == RUN)
                m_exp = (2*W)'(mcand) * (2*W)'(mplier);
            m_busy = m_busy - 1;
            if (m_busy == 0 && m_run) begin
                m_done = 1'b1;
                m_run  = 1'b0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cycles, act, exp);
        end
    endtask

    // Per-cycle compare, away from the active edge
    always @(negedge clk) begin
        if (!finished) begin
            if (!rst_n) begin
                chk(idle == 1'b0 && done == 1'b0 && product == '0, "R1 reset outputs",
                    {idle, done, product}, 0);
            end else begin
                chk(idle == (m_busy == 0), "R2/R3 idle", idle, m_busy == 0);
                chk(done == m_done, "R3/R7 done", done, m_done);
                if (m_done) chk(product == m_exp, {"R4 product ", tag}, product, m_exp);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !finished) begin
            fails++;
            $display("FAIL watchdog expired");
            finish_up();
        end
    end

    task automatic finish_up();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic run(input logic [W-1:0] a, input logic [W-1:0] b,
                       input bit scramble, input bit poke, input string t);
        tag = t;
        while (!idle) @(negedge clk);
        mcand = a; mplier = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        if (scramble) begin          // R5: operands changed after capture
            mcand = ~a; mplier = b ^ 8'h5a;
        end
        if (poke) begin              // R6: start during a run
            repeat (3) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        repeat (3) @(negedge clk);   // R7: hold while idle
        mcand = $urandom; mplier = $urandom;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(idle == 1'b1, "R1 idle after first edge", idle, 1);
        repeat (4) @(negedge clk);   // R2: start low keeps idle
        chk(idle == 1'b1 && done == 1'b0, "R2 stays idle", idle, 1);
        run(8'd23, 8'd19, 1'b0, 1'b0, "R4 23x19");
        chk(product == 16'd437, "R4 23x19=437", product, 437);
        run(8'd0, 8'd200, 1'b0, 1'b0, "R4 zero");
        run(8'hff, 8'hff, 1'b0, 1'b0, "R4 max");
        chk(product == 16'hfe01, "R4 max product", product, 16'hfe01);
        run(8'd77, 8'd141, 1'b1, 1'b0, "R5 scramble");
        run(8'd200, 8'd3, 1'b0, 1'b1, "R6 poke");
        for (int i = 0; i < 20; i++)
            run($urandom, $urandom, i[0], i[1], "R4 random");
        finish_up();
    end

endmodule